// File: doc/BRIEF.md
# Segment LCD Display Memory

This block stores the on/off pattern for a segment LCD driver with 48 drive pins. Each pin owns one byte, and each set bit lights one segment. A pin that serves as a common line keeps its common-number assignment in that same byte. A simple register bus can read or write one byte, or two neighbouring bytes as a 16-bit word.

The display scanner drives one common phase at a time. For that phase it reads a 48-bit column: one bit from every pin byte. The configured multiplex ratio sets which bits are visible. With four or fewer commons, the upper nibble of every byte is hidden from both the bus and the scanner. The storage itself keeps all eight bits.

A clear-all request empties the whole memory. It walks the memory one byte per clock. A status bit stays high while it runs and then drops by itself. Bus writes issued during the walk are held off. The block also reports how many segments the current ratio can drive, given that every common takes a pin away from segment duty.

Top module: `lcd_seg_memory`

## Requirements
- R1: After reset every byte reads 0, `clr_busy` is 0, `bus_ready` is 1 and `scan_column` is all zeros.
- R2: A byte access (`bus_word`=0) to address 0..47 writes `bus_wdata[7:0]` into that pin's byte when `bus_sel`, `bus_wr` and `bus_ready` are high at a rising clock edge. A byte read returns `{8'h00, masked byte}` combinationally.
- R3: A word access (`bus_word`=1) ignores address bit 0 and targets the even byte E and the byte E+1. A write puts `bus_wdata[7:0]` in E and `bus_wdata[15:8]` in E+1. A read returns `{byte E+1, byte E}`, each masked.
- R4: A write to an address of 48 or above changes nothing. A read of a byte at such an address returns 0.
- R5: `mux_ratio` codes 0..3 mean 1..4 commons. With these codes, bits 7:4 of every byte read as 0 on the bus and on the scanner. The stored bits are kept and reappear when a code of 4 or above is selected.
- R6: `mux_ratio` codes 4..7 mean 5..8 commons. With these codes all eight bits of every byte are visible.
- R7: `scan_column[i]` equals bit `scan_phase` of the masked byte of pin i.
- R8: A `clear_req` sampled high while idle sets `clr_busy` from the next cycle. `clr_busy` then stays high for exactly 48 cycles, zeroing one byte per cycle from pin 0 upward, and then returns to 0 by itself. Afterwards every byte reads 0.
- R9: While `clr_busy` is high, a write request sees `bus_ready`=0 and changes no byte. Read requests keep `bus_ready`=1.
- R10: `seg_capacity` equals c × (48 − c), where c = `mux_ratio` + 1 (47 for code 0, 176 for code 3, 320 for code 7).
- R11: A `clear_req` raised while a clear is already running has no effect: the running clear is not restarted or lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| bus_addr | input | 6 | Byte address (pin number) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Masked read data |
| bus_ready | output | 1 | Low while a write is stalled by a clear |
| mux_ratio | input | 3 | Commons minus one (0 = static, 7 = 8 commons) |
| clear_req | input | 1 | Start of a clear-all sweep |
| clr_busy | output | 1 | Clear-all in progress; self-clearing |
| scan_phase | input | 3 | Common phase requested by the scanner |
| scan_column | output | 48 | One masked bit per pin for that phase |
| seg_capacity | output | 9 | Segment count the current ratio can drive |

## Verification
The assertions assume that a requester treats a write as done only at an edge where `bus_ready` is high. The sweep checks also assume `clear_req` is a plain synchronous level that may arrive at any time, including during a running clear. The stimulus drives all inputs half a cycle away from the active edge. It holds a stalled write for one cycle only and then withdraws it, so no write ever coincides with a clear step. It raises a second clear request partway through a sweep to exercise the case where that request must be ignored.

// File: rtl/lcdmem_pkg.sv
package lcdmem_pkg;

    localparam int BYTE_W     = 8;
    localparam int MUX_CODE_W = 3;
    // Codes up to this value drive at most four commons.
    localparam int NARROW_LAST_CODE = 3;

    // Visible-bit mask for a given multiplex code.
    function automatic logic [BYTE_W-1:0] visible_mask(input logic [MUX_CODE_W-1:0] code);
        if (int'(code) <= NARROW_LAST_CODE) begin
            return 8'h0F;
        end
        return 8'hFF;
    endfunction

endpackage

// File: rtl/lcdmem_bus_decode.sv
module lcdmem_bus_decode
    import lcdmem_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 6
) (
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic                   bus_word,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [2*BYTE_W-1:0]    bus_wdata,
    input  logic                   clr_busy,
    output logic                   bus_ready,
    output logic [NUM_PINS-1:0]    wr_en,
    output logic [BYTE_W-1:0]      lane_even,
    output logic [BYTE_W-1:0]      lane_odd,
    output logic [ADDR_W-1:0]      lo_idx,
    output logic [ADDR_W-1:0]      hi_idx,
    output logic                   lo_hit,
    output logic                   hi_hit
);

    logic accept_wr;

    always_comb begin
        bus_ready = !(clr_busy && bus_sel && bus_wr);
        accept_wr = bus_sel && bus_wr && !clr_busy;

        lo_idx = bus_word ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
        hi_idx = {bus_addr[ADDR_W-1:1], 1'b1};
        lo_hit = (int'(lo_idx) < NUM_PINS);
        hi_hit = bus_word && (int'(hi_idx) < NUM_PINS);

        if (bus_word) begin
            lane_even = bus_wdata[BYTE_W-1:0];
            lane_odd  = bus_wdata[2*BYTE_W-1:BYTE_W];
        end else begin
            lane_even = bus_wdata[BYTE_W-1:0];
            lane_odd  = bus_wdata[BYTE_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_wen
        assign wr_en[g] = accept_wr &&
                          ((lo_hit && (lo_idx == ADDR_W'(g))) ||
                           (hi_hit && (hi_idx == ADDR_W'(g))));
    end

endmodule

// File: rtl/lcdmem_clear_seq.sv
module lcdmem_clear_seq #(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_req,
    output logic                busy,
    output logic [NUM_PINS-1:0] clr_en
);

    localparam int PTR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_PINS - 1);

    typedef struct packed {
        logic             busy;
        logic [PTR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.ptr == LAST_PTR) begin
                seq_d.busy = 1'b0;
                seq_d.ptr  = '0;
            end else begin
                seq_d.ptr = seq_q.ptr + 1'b1;
            end
        end else if (clear_req) begin
            seq_d.busy = 1'b1;
            seq_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_clr
        assign clr_en[g] = seq_q.busy && (seq_q.ptr == PTR_W'(g));
    end

    // R8: sweep finishes right after the last pin
    p_sweep_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.ptr == LAST_PTR) |=> !seq_q.busy);

    p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.ptr <= LAST_PTR));

    // R11: a request during a sweep does not restart it
    p_req_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.ptr != LAST_PTR && clear_req)
        |=> (seq_q.busy && (seq_q.ptr - $past(seq_q.ptr)) == PTR_W'(1)));

endmodule

// File: rtl/lcdmem_array.sv
module lcdmem_array
    import lcdmem_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             wr_en,
    input  logic [NUM_PINS-1:0]             clr_en,
    input  logic [BYTE_W-1:0]               lane_even,
    input  logic [BYTE_W-1:0]               lane_odd,
    output logic [NUM_PINS-1:0][BYTE_W-1:0] cells
);

    typedef struct packed {
        logic [NUM_PINS-1:0][BYTE_W-1:0] cells;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (clr_en[i]) begin
                store_d.cells[i] = '0;
            end else if (wr_en[i]) begin
                store_d.cells[i] = (i % 2 == 0) ? lane_even : lane_odd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign cells = store_q.cells;

    // R8: the sweep touches at most one byte per cycle
    p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_en));

    // R9: no write is issued while the sweep owns the memory
    p_no_write_in_sweep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_en) |-> (wr_en == '0));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        p_cleared_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en[g] |=> (store_q.cells[g] == '0));
    end

endmodule

// File: rtl/lcd_seg_memory.sv
module lcd_seg_memory
    import lcdmem_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 6,
    parameter int CAP_W    = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_word,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  bus_ready,
    input  logic [2:0]            mux_ratio,
    input  logic                  clear_req,
    output logic                  clr_busy,
    input  logic [2:0]            scan_phase,
    output logic [NUM_PINS-1:0]   scan_column,
    output logic [CAP_W-1:0]      seg_capacity
);

    logic [NUM_PINS-1:0]             wr_en;
    logic [NUM_PINS-1:0]             clr_en;
    logic [BYTE_W-1:0]               lane_even;
    logic [BYTE_W-1:0]               lane_odd;
    logic [ADDR_W-1:0]               lo_idx;
    logic [ADDR_W-1:0]               hi_idx;
    logic                            lo_hit;
    logic                            hi_hit;
    logic [NUM_PINS-1:0][BYTE_W-1:0] cells;
    logic [NUM_PINS-1:0][BYTE_W-1:0] shown;
    logic [BYTE_W-1:0]               mask;
    logic [BYTE_W-1:0]               rd_lo;
    logic [BYTE_W-1:0]               rd_hi;

    lcdmem_bus_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .clr_busy  (clr_busy),
        .bus_ready (bus_ready),
        .wr_en     (wr_en),
        .lane_even (lane_even),
        .lane_odd  (lane_odd),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx),
        .lo_hit    (lo_hit),
        .hi_hit    (hi_hit)
    );

    lcdmem_clear_seq #(.NUM_PINS(NUM_PINS)) i_clear (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (clear_req),
        .busy      (clr_busy),
        .clr_en    (clr_en)
    );

    lcdmem_array #(.NUM_PINS(NUM_PINS)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .clr_en    (clr_en),
        .lane_even (lane_even),
        .lane_odd  (lane_odd),
        .cells     (cells)
    );

    assign mask = visible_mask(mux_ratio);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_view
        assign shown[g]       = cells[g] & mask;
        assign scan_column[g] = shown[g][scan_phase];
    end

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (lo_hit && lo_idx == ADDR_W'(i)) rd_lo = shown[i];
            if (hi_hit && hi_idx == ADDR_W'(i)) rd_hi = shown[i];
        end
        bus_rdata = {rd_hi, rd_lo};
    end

    always_comb begin
        int commons;
        commons      = int'(mux_ratio) + 1;
        seg_capacity = CAP_W'(commons * (NUM_PINS - commons));
    end

    // R9: a write request during a sweep is stalled
    p_write_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && bus_sel && bus_wr) |-> !bus_ready);

    // R5: hidden phases of narrow ratios never light a segment
    p_scan_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mux_ratio) <= NARROW_LAST_CODE && scan_phase[2]) |-> (scan_column == '0));

    // R10: capacity never exceeds the pin count times the widest ratio
    p_cap_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(seg_capacity) <= 8 * NUM_PINS);

endmodule

// File: tb/test_lcd_seg_memory.sv
module test_lcd_seg_memory;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ready;
    logic [2:0]  mux_ratio = 3'd7;
    logic        clear_req = 1'b0;
    logic        clr_busy;
    logic [2:0]  scan_phase = '0;
    logic [N-1:0] scan_column;
    logic [8:0]  seg_capacity;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [N];

    always #4 clk = ~clk;

    lcd_seg_memory i_lcd_seg_memory (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .mux_ratio(mux_ratio), .clear_req(clear_req),
        .clr_busy(clr_busy), .scan_phase(scan_phase), .scan_column(scan_column),
        .seg_capacity(seg_capacity)
    );

    typedef struct packed {
        logic        word;
        logic [5:0]  waddr;
        logic [15:0] wdata;
        logic [2:0]  mux;
        logic        rword;
        logic [5:0]  raddr;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 6'd0,  16'h00A5, 3'd7, 1'b0, 6'd0,  16'h00A5},
        '{1'b0, 6'd5,  16'h003C, 3'd3, 1'b0, 6'd5,  16'h000C},
        '{1'b1, 6'd10, 16'hBEEF, 3'd7, 1'b1, 6'd10, 16'hBEEF},
        '{1'b1, 6'd13, 16'h1234, 3'd7, 1'b0, 6'd13, 16'h0012},
        '{1'b0, 6'd47, 16'h00FF, 3'd0, 1'b0, 6'd47, 16'h000F},
        '{1'b0, 6'd50, 16'h0077, 3'd7, 1'b0, 6'd50, 16'h0000},
        '{1'b1, 6'd20, 16'h9A56, 3'd1, 1'b1, 6'd20, 16'h0A06},
        '{1'b0, 6'd33, 16'h0081, 3'd4, 1'b0, 6'd33, 16'h0081}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic word, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic word, input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] vis(input logic [7:0] b, input logic [2:0] m);
        return (m <= 3'd3) ? (b & 8'h0F) : b;
    endfunction

    task automatic check_scan(input logic [2:0] m, input string req);
        for (int ph = 0; ph < 8; ph++) begin
            logic [N-1:0] exp_col;
            @(negedge clk);
            mux_ratio = m; scan_phase = 3'(ph);
            for (int p = 0; p < N; p++) exp_col[p] = vis(model[p], m)[ph];
            #1 check(scan_column == exp_col, req, scan_column, exp_col);
        end
    endtask

    initial begin
        #150000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int busy_cycles;
        for (int p = 0; p < N; p++) model[p] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(clr_busy == 1'b0 && bus_ready == 1'b1, "R1 idle after reset", {clr_busy, bus_ready}, 2'b01);
        check(scan_column == '0, "R1 scan zero", scan_column, 0);
        bus_read(1'b1, 6'd46, rd);
        check(rd == 16'h0, "R1 reads zero", rd, 0);

        // R2 R3 R4 R5 R6: vector table
        foreach (VECS[k]) begin
            @(negedge clk);
            mux_ratio = VECS[k].mux;
            bus_write(VECS[k].word, VECS[k].waddr, VECS[k].wdata);
            if (VECS[k].word) begin
                int e;
                e = int'(VECS[k].waddr) & ~1;
                if (e < N) model[e] = VECS[k].wdata[7:0];
                if (e + 1 < N) model[e+1] = VECS[k].wdata[15:8];
            end else if (int'(VECS[k].waddr) < N) begin
                model[VECS[k].waddr] = VECS[k].wdata[7:0];
            end
            bus_read(VECS[k].rword, VECS[k].raddr, rd);
            check(rd == VECS[k].exp, $sformatf("R2/R3/R4/R5/R6 vector %0d", k), rd, VECS[k].exp);
        end

        // R3: even byte of the odd-address word write
        bus_read(1'b0, 6'd12, rd);
        check(rd == 16'h0034, "R3 odd address word low byte", rd, 16'h0034);

        // R5: hidden bits survive and reappear under wider ratio
        mux_ratio = 3'd0;
        bus_read(1'b1, 6'd10, rd);
        check(rd == 16'h0E0F, "R5 narrow word read", rd, 16'h0E0F);
        mux_ratio = 3'd6;
        bus_read(1'b0, 6'd47, rd);
        check(rd == 16'h00FF, "R5 R6 stored nibble reappears", rd, 16'h00FF);

        // R7: scanner columns
        check_scan(3'd7, "R7 scan wide");
        check_scan(3'd2, "R7 R5 scan narrow");

        // R10: capacity
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mux_ratio = 3'(m);
            #1 check(int'(seg_capacity) == (m + 1) * (N - m - 1), "R10 capacity", seg_capacity, (m + 1) * (N - m - 1));
        end
        mux_ratio = 3'd7;

        // R8 R9 R11: clear sweep
        @(negedge clk);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        check(clr_busy == 1'b1, "R8 busy after request", clr_busy, 1);
        busy_cycles = 0;
        while (clr_busy && busy_cycles < 200) begin
            if (busy_cycles == 3) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b0; bus_addr = 6'd3; bus_wdata = 16'h00EE;
                #1 check(bus_ready == 1'b0, "R9 write stalled", bus_ready, 0);
            end
            if (busy_cycles == 5) begin
                bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'd40;
                #1 check(bus_ready == 1'b1, "R9 read not stalled", bus_ready, 1);
            end
            if (busy_cycles == 10) clear_req = 1'b1;
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; clear_req = 1'b0;
            busy_cycles++;
        end
        check(busy_cycles == N, "R8 R11 sweep length", busy_cycles, N);
        check(bus_ready == 1'b1, "R8 ready after sweep", bus_ready, 1);
        for (int p = 0; p < N; p += 2) begin
            bus_read(1'b1, 6'(p), rd);
            check(rd == 16'h0, $sformatf("R8 R9 cleared word %0d", p), rd, 0);
        end
        for (int p = 0; p < N; p++) model[p] = '0;
        check_scan(3'd7, "R8 scan after clear");

        // R2: write works again after sweep
        bus_write(1'b0, 6'd3, 16'h0055);
        bus_read(1'b0, 6'd3, rd);
        check(rd == 16'h0055, "R2 write after clear", rd, 16'h0055);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule